// File: doc/BRIEF.md
# General-Purpose I/O Port with Half-Cycle Input Synchronizer

This block is one parallel I/O port of W pins (8 by default). For every pin, software chooses a direction and a level. On a pin set as output, the pad is driven with that level. On a pin set as input, a level bit of 1 turns on a weak pull-up and a 0 leaves the pin floating. A third, read-only register returns the real pad levels. That register samples the pads through a two-stage synchronizer: a capture stage that holds the pad level from the falling clock edge, followed by a rising-edge register.

Software reaches the port through a single-cycle register interface with a 2-bit address. Writes take effect at the rising clock edge, and reads are combinational in the same cycle. The pad side is a plain tri-state model. The port outputs a drive value, a drive enable and a pull-up enable, and it receives the resolved pad level back.

The synchronizer sets the input timing. A change on an external pin shows up in the pin register between half a cycle and one and a half cycles after it happens. A level that software has just written reaches the pin register exactly one cycle after the write edge. For this reason a read issued in the cycle right after the write still returns the old level.

Top module: `gpio_port`

## Requirements
- R1: Synchronous reset clears the direction and level registers to 0, so every pin is an input with no drive and no pull-up.
- R2: Address 1 is the direction register and address 2 is the level register. Both are written at the rising edge when `reg_we` is high, and both read back combinationally in the same cycle. Address 3 reads as 0.
- R3: A write to address 0 (the pin register) changes neither the direction register, the level register, nor any pad control output.
- R4: For each pin, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its level bit.
- R5: For each pin, `pad_pu` is 1 exactly when the direction bit is 0 and the level bit is 1. An input pin with a level bit of 0 gets no pull-up and floats.
- R6: A pad change that arrives while the clock is high is visible at address 0 after the next rising edge, no sooner than half a clock period after the change.
- R7: A pad change that arrives while the clock is low is not visible after the next rising edge. It becomes visible after the rising edge that follows, within one and a half clock periods of the change.
- R8: After a write to the level register on a pin set as output, a read of address 0 in the next cycle returns the old level. A read one cycle later returns the new level.
- R9: Address 0 reflects each pin's pad level independently, whether that level comes from the port's own drive, an external source, or a pull-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 pin, 1 direction, 2 level) |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Combinational read data |
| pad_in | input | W | Resolved pad levels |
| pad_out | output | W | Drive value for each pad |
| pad_oe | output | W | Drive enable for each pad |
| pad_pu | output | W | Weak pull-up enable for each pad |

## Verification
The hardest conditions to reach are the two latency bounds. They depend on where within one clock period the external pad changes, and the register interface alone cannot place such a change. The bench therefore moves its external pad source at fixed offsets after a rising edge: two offsets in the high phase, one of them just before the falling edge, and one in the low phase. It then reads the pin register on both sides of the following rising edges. The readback-after-write case is reached by reading the pin register in the cycle right after the write edge and again one cycle later.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_PIN   = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_LEVEL = 2'd2,
        SEL_NONE  = 2'd3
    } gpio_sel_e;

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  gpio_sel_e    sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lvl_q
);

    logic dir_hit;
    logic lvl_hit;

    // pin register address is read-only: no write enable derived from it
    assign dir_hit = we && (sel == SEL_DIR);
    assign lvl_hit = we && (sel == SEL_LEVEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            if (dir_hit) dir_q <= wdata;
            if (lvl_hit) lvl_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lvl_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_oe[i]  = dir_q[i];
        assign pad_out[i] = lvl_q[i];
        assign pad_pu[i]  = ~dir_q[i] & lvl_q[i];
    end

endmodule

// File: rtl/gpio_half_sync.sv
module gpio_half_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pin_q
);

    logic [W-1:0] hold_q;

    for (genvar i = 0; i < W; i++) begin : g_stage
        // first stage: value held from the moment the clock goes low,
        // the only value the rising-edge stage ever observes
        always_ff @(negedge clk) begin
            hold_q[i] <= pad_in[i];
        end

        // second stage: rising-edge pin register
        always_ff @(posedge clk) begin
            pin_q[i] <= hold_q[i];
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);

    gpio_sel_e    sel;
    logic [W-1:0] dir_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] pin_q;

    assign sel = gpio_sel_e'(reg_addr);

    gpio_ctrl_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (sel),
        .wdata (reg_wdata),
        .dir_q (dir_q),
        .lvl_q (lvl_q)
    );

    gpio_pad_ctrl #(.W(W)) u_pad (
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    gpio_half_sync #(.W(W)) u_sync (
        .clk    (clk),
        .pad_in (pad_in),
        .pin_q  (pin_q)
    );

    always_comb begin
        unique case (sel)
            SEL_PIN:   reg_rdata = pin_q;
            SEL_DIR:   reg_rdata = dir_q;
            SEL_LEVEL: reg_rdata = lvl_q;
            SEL_NONE:  reg_rdata = '0;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_we,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] reg_rdata,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu
);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            p_reset_clear_r1: assert (pad_oe == '0 && pad_pu == '0 && pad_out == '0);
        end
    end

    p_dir_write_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd1) |=> (pad_oe == $past(reg_wdata)));

    p_lvl_write_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd2) |=> (pad_out == $past(reg_wdata)));

    p_pin_ro_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd0) |=>
            ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

    p_pin_settles_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0 && pad_in === $past(pad_in) && pad_in === $past(pad_in, 2))
            |-> (reg_rdata === pad_in));

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd3) |-> (reg_rdata == '0));

endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;

    localparam int W = 8;
    localparam int K_RD = 0;
    localparam int K_OE = 1;
    localparam int K_PU = 2;
    localparam int K_OUT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pad_in;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_pu;

    logic [W-1:0] ext_en = '0;
    logic [W-1:0] ext_val = '0;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    int         kind_q[$];
    logic [W-1:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    always #5 clk = ~clk;

    // pad resolution: own drive, then external source, then pull-up, else unknown
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (pad_oe[i])       pad_in[i] = pad_out[i];
            else if (ext_en[i])  pad_in[i] = ext_val[i];
            else if (pad_pu[i])  pad_in[i] = 1'b1;
            else                 pad_in[i] = 1'bx;
        end
    end

    gpio_port #(.W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu)
    );

    // monitor: pops expectations and compares against the live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (kind_q.size() > 0) begin
                int k;
                logic [W-1:0] e;
                logic [W-1:0] a;
                string t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                case (k)
                    K_RD:    a = reg_rdata;
                    K_OE:    a = pad_oe;
                    K_PU:    a = pad_pu;
                    default: a = pad_out;
                endcase
                n_checks++;
                if (a !== e) begin
                    n_fails++;
                    $display("FAIL %s: actual %b expected %b at %0t", t, a, e, $time);
                end
            end
        end
    end

    task automatic expect_out(input int kind, input logic [W-1:0] e, input string tag);
        kind_q.push_back(kind);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> sample_ev;
        #0;
    endtask

    task automatic expect_read(input logic [1:0] a, input logic [W-1:0] e, input string tag);
        reg_addr = a;
        #1;
        expect_out(K_RD, e, tag);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset has been applied
        expect_out(K_OE, 8'h00, "R1 oe in reset");
        expect_out(K_PU, 8'h00, "R1 pu in reset");
        @(negedge clk);
        rst = 1'b0;
        expect_read(2'd1, 8'h00, "R1 dir after reset");
        expect_read(2'd2, 8'h00, "R1 level after reset");

        // R2, R4, R5: program directions and levels
        reg_write(2'd1, 8'h0F);
        reg_write(2'd2, 8'h35);
        expect_read(2'd1, 8'h0F, "R2 dir readback");
        expect_read(2'd2, 8'h35, "R2 level readback");
        expect_read(2'd3, 8'h00, "R2 unused address");
        expect_out(K_OE, 8'h0F, "R4 drive enable");
        expect_out(K_OUT, 8'h35, "R4 drive value");
        expect_out(K_PU, 8'h30, "R5 pull-up on inputs with level 1");

        // R9: mixed sources, high nibble external
        ext_en = 8'hF0;
        ext_val = 8'hA0;
        repeat (3) @(negedge clk);
        expect_read(2'd0, 8'hA5, "R9 mixed drive and external");
        // R5, R9: release external, pull-ups read 1, others float
        ext_en = 8'h00;
        repeat (3) @(negedge clk);
        expect_read(2'd0, 8'bxx11_0101, "R5 pull-up and floating pins");

        // R3: write to pin address is ignored
        reg_write(2'd0, 8'hFF);
        expect_read(2'd1, 8'h0F, "R3 dir unchanged");
        expect_read(2'd2, 8'h35, "R3 level unchanged");
        expect_out(K_PU, 8'h30, "R3 pull-up unchanged");

        // R8: readback of a level just written
        ext_en = 8'hF0;
        ext_val = 8'h00;
        repeat (3) @(negedge clk);
        reg_write(2'd2, 8'h3A);
        expect_read(2'd0, 8'h05, "R8 read right after write shows old level");
        @(negedge clk);
        expect_read(2'd0, 8'h0A, "R8 read one cycle later shows new level");

        // R6: change early in the high phase
        @(posedge clk);
        #2 ext_val = 8'h80;
        #4;
        expect_read(2'd0, 8'h0A, "R6 not visible before next rising edge");
        #4;
        expect_read(2'd0, 8'h8A, "R6 visible after next rising edge");

        // R6: change just before the falling edge
        @(posedge clk);
        #4 ext_val = 8'h00;
        #2;
        expect_read(2'd0, 8'h8A, "R6 late high phase old before edge");
        #4;
        expect_read(2'd0, 8'h0A, "R6 late high phase new after edge");

        // R7: change in the low phase
        @(posedge clk);
        #7 ext_val = 8'h40;
        #5;
        expect_read(2'd0, 8'h0A, "R7 not visible after first rising edge");
        #8;
        expect_read(2'd0, 8'h4A, "R7 visible after second rising edge");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule